// File: doc/BRIEF.md
# Shared Waveform Generator Bank

The bank holds eight blink/PWM waveform generators that are shared among 33 output pins: 16 direct pins and 17 pins bound for an external serial expander. Each generator repeats a pattern of a programmed number of high steps followed by a programmed number of low steps. Every step lasts a programmed count of time-base pulses. A per-pin map picks the generator that drives each pin and gates the pin on or off. Because there are only eight generators, at most eight distinct period and duty pairs can be active at once.

Software fills a small register file through a single-cycle write port and reads it back through a combinational read port. The time base comes in as a one-cycle pulse, `tick_i`. With the intended rate of 255 pulses per 4 ms, and with low programmed as 255 minus high, the period register counts in 4 ms units (legal range 1 to 250) and the high byte gives the duty in 255ths. Writes to a running generator are held back until its current period ends, so the pattern on the pin never breaks in the middle. Shifting of the serial pins is done outside this block.

Top module: `wgb_bank`

## Requirements
- R1: After reset every pin output is low and every register word reads 0.
- R2: Register layout, by word address:
  - Words 0 and 1 hold the 8-bit periods, four generators per word. Generator g sits at word g/4, bits [(g%4)*8 +: 8].
  - Words 2 to 5 hold the duty, two generators per word. Generator g sits at word 2+g/2, in the 16-bit half (g%2). The high count is in bits [7:0] of the half and the low count in bits [15:8].
  - Words 6 and 7 map direct pins 0 to 15. Words 8 to 10 map serial pins 16 to 32. Pin p sits at nibble p%8 of its group's word, counted from the first pin of the group. Within a nibble, bit 3 is enable and bits [2:0] are the generator index.
  - Writes are full-word. A read returns the last value written to every field. Unused bits of word 10 (bits [31:4]) and addresses 11 to 15 read 0 and store nothing.
- R3: A pin whose enable bit is clear is low. An enabled pin carries the waveform of its selected generator in the same cycle. Direct pins are `pins_o[15:0]` and serial pins are `pins_o[32:16]`.
- R4: A running generator with period P, high H and low L is high for H steps and then low for L steps, and repeats. One step is P pulses of `tick_i`, so one period is P*(H+L) pulses. If H+L is 0, the output is low and the period is P pulses. Clock cycles without a tick leave the waveform where it is.
- R5: A generator whose active period is 0 is idle: its output is low and it does not count. While it is idle it takes its programmed values on every clock. A nonzero period therefore starts a fresh period, high first, one clock after the write.
- R6: H=255 with L=0 gives a constant high output. H=0 gives a constant low output.
- R7: Writing period or duty values to a running generator does not change its output until the period in progress ends. The new values take effect from the next period.
- R8: If a write lands in the same clock as the end of a period, that boundary loads the values held before the write. The written values take effect one period later.
- R9: Any number of pins may select the same generator and then carry identical waveforms. The eight generators run independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base step pulse, one cycle wide |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| pins_o | output | 33 | Pin levels: [15:0] direct, [32:16] serial |

## Verification
Two events can coincide. A register write to a running generator's period or duty can fall in the very clock in which that generator's current period ends, and the two must not blend: the boundary must load the previous values (R8).

The bench provokes this by following its own model of elapsed ticks and placing the write strobe exactly on the final tick of the period. It then checks that the next period still shows the old high/low split and that the new split appears only one full period later. Every pin is also compared with the model on every clock during this sequence.

// File: rtl/wgb_pkg.sv
package wgb_pkg;
  localparam int PER_W          = 8;
  localparam int DUTY_W         = 8;
  localparam int NIB_W          = 4;
  localparam int PERS_PER_WORD  = 32 / PER_W;
  localparam int DUTY_PER_WORD  = 32 / (2 * DUTY_W);
  localparam int PINS_PER_WORD  = 32 / NIB_W;

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/wgb_regs.sv
module wgb_regs
  import wgb_pkg::*;
#(
  parameter int NUM_GEN = 8,
  parameter int NUM_DIR = 16,
  parameter int NUM_SER = 17,
  parameter int AW      = 4,
  localparam int NUM_PINS = NUM_DIR + NUM_SER,
  localparam int SEL_W    = $clog2(NUM_GEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [PER_W-1:0]   per_o   [NUM_GEN],
  output logic [DUTY_W-1:0]  hi_o    [NUM_GEN],
  output logic [DUTY_W-1:0]  lo_o    [NUM_GEN],
  output logic               pin_en_o  [NUM_PINS],
  output logic [SEL_W-1:0]   pin_sel_o [NUM_PINS]
);
  localparam int PER_BASE   = 0;
  localparam int PER_WORDS  = ceil_div(NUM_GEN, PERS_PER_WORD);
  localparam int DUTY_BASE  = PER_BASE + PER_WORDS;
  localparam int DUTY_WORDS = ceil_div(NUM_GEN, DUTY_PER_WORD);
  localparam int DMAP_BASE  = DUTY_BASE + DUTY_WORDS;
  localparam int DMAP_WORDS = ceil_div(NUM_DIR, PINS_PER_WORD);
  localparam int SMAP_BASE  = DMAP_BASE + DMAP_WORDS;

  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr_i);

  function automatic int pin_word(int p);
    return (p < NUM_DIR) ? DMAP_BASE + p / PINS_PER_WORD
                         : SMAP_BASE + (p - NUM_DIR) / PINS_PER_WORD;
  endfunction

  function automatic int pin_nib(int p);
    return ((p < NUM_DIR) ? p : p - NUM_DIR) % PINS_PER_WORD;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_GEN; g++) begin
        per_o[g] <= '0;
        hi_o[g]  <= '0;
        lo_o[g]  <= '0;
      end
      for (int p = 0; p < NUM_PINS; p++) begin
        pin_en_o[p]  <= 1'b0;
        pin_sel_o[p] <= '0;
      end
    end else if (we_i) begin
      for (int g = 0; g < NUM_GEN; g++) begin
        if (addr_ext == 32'(PER_BASE + g / PERS_PER_WORD))
          per_o[g] <= wdata_i[(g % PERS_PER_WORD) * PER_W +: PER_W];
        if (addr_ext == 32'(DUTY_BASE + g / DUTY_PER_WORD)) begin
          hi_o[g] <= wdata_i[(g % DUTY_PER_WORD) * 2 * DUTY_W +: DUTY_W];
          lo_o[g] <= wdata_i[(g % DUTY_PER_WORD) * 2 * DUTY_W + DUTY_W +: DUTY_W];
        end
      end
      for (int p = 0; p < NUM_PINS; p++) begin
        if (addr_ext == 32'(pin_word(p))) begin
          pin_en_o[p]  <= wdata_i[pin_nib(p) * NIB_W + NIB_W - 1];
          pin_sel_o[p] <= wdata_i[pin_nib(p) * NIB_W +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (addr_ext == 32'(PER_BASE + g / PERS_PER_WORD))
        rdata_o[(g % PERS_PER_WORD) * PER_W +: PER_W] = per_o[g];
      if (addr_ext == 32'(DUTY_BASE + g / DUTY_PER_WORD)) begin
        rdata_o[(g % DUTY_PER_WORD) * 2 * DUTY_W +: DUTY_W]          = hi_o[g];
        rdata_o[(g % DUTY_PER_WORD) * 2 * DUTY_W + DUTY_W +: DUTY_W] = lo_o[g];
      end
    end
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr_ext == 32'(pin_word(p))) begin
        rdata_o[pin_nib(p) * NIB_W + NIB_W - 1]  = pin_en_o[p];
        rdata_o[pin_nib(p) * NIB_W +: SEL_W]     = pin_sel_o[p];
      end
    end
  end
endmodule

// File: rtl/wgb_gen.sv
module wgb_gen
  import wgb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [PER_W-1:0]  per_i,
  input  logic [DUTY_W-1:0] hi_i,
  input  logic [DUTY_W-1:0] lo_i,
  output logic              wave_o
);
  localparam int STEP_W = DUTY_W + 1;

  logic [PER_W-1:0]  act_per_q, pre_q;
  logic [DUTY_W-1:0] act_hi_q, act_lo_q;
  logic [STEP_W-1:0] step_q, step_sum, last_step;
  logic running, pre_end, cyc_end;

  assign step_sum  = STEP_W'(act_hi_q) + STEP_W'(act_lo_q);
  assign last_step = (step_sum == '0) ? '0 : step_sum - 1'b1;
  assign running   = act_per_q != '0;
  assign pre_end   = pre_q == act_per_q - 1'b1;
  assign cyc_end   = tick_i && running && pre_end && (step_q == last_step);

  // idle generators track the programmed values; running ones reload only at period end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_per_q <= '0;
      act_hi_q  <= '0;
      act_lo_q  <= '0;
      pre_q     <= '0;
      step_q    <= '0;
    end else if (!running || cyc_end) begin
      act_per_q <= per_i;
      act_hi_q  <= hi_i;
      act_lo_q  <= lo_i;
      pre_q     <= '0;
      step_q    <= '0;
    end else if (tick_i) begin
      if (pre_end) begin
        pre_q  <= '0;
        step_q <= step_q + 1'b1;
      end else begin
        pre_q  <= pre_q + 1'b1;
      end
    end
  end

  assign wave_o = running && (step_q < STEP_W'(act_hi_q));

  a_r4_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !tick_i) |=> ($stable(step_q) && $stable(pre_q)));

  a_r4_step_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> ((step_q <= last_step) && (pre_q < act_per_q)));

  a_r7_cfg_held_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !cyc_end) |=> ($stable(act_per_q) && $stable(act_hi_q) && $stable(act_lo_q)));

  a_r6_full_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && act_hi_q == '1 && act_lo_q == '0) |-> wave_o);

  a_r5_idle_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |=> (step_q == '0 && pre_q == '0));
endmodule

// File: rtl/wgb_pinmux.sv
module wgb_pinmux #(
  parameter int NUM_GEN  = 8,
  parameter int NUM_PINS = 33,
  localparam int SEL_W   = $clog2(NUM_GEN)
) (
  input  logic [NUM_GEN-1:0]  wave_i,
  input  logic                pin_en_i  [NUM_PINS],
  input  logic [SEL_W-1:0]    pin_sel_i [NUM_PINS],
  output logic [NUM_PINS-1:0] pins_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pins_o[p] = pin_en_i[p] & wave_i[pin_sel_i[p]];
  end
endmodule

// File: rtl/wgb_bank.sv
module wgb_bank
  import wgb_pkg::*;
#(
  parameter int NUM_GEN = 8,
  parameter int NUM_DIR = 16,
  parameter int NUM_SER = 17,
  localparam int NUM_PINS  = NUM_DIR + NUM_SER,
  localparam int NUM_WORDS = ceil_div(NUM_GEN, PERS_PER_WORD) + ceil_div(NUM_GEN, DUTY_PER_WORD)
                           + ceil_div(NUM_DIR, PINS_PER_WORD) + ceil_div(NUM_SER, PINS_PER_WORD),
  localparam int AW        = $clog2(NUM_WORDS),
  localparam int SEL_W     = $clog2(NUM_GEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                reg_we_i,
  input  logic [AW-1:0]       reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic [NUM_PINS-1:0] pins_o
);
  logic [PER_W-1:0]  per [NUM_GEN];
  logic [DUTY_W-1:0] hi  [NUM_GEN];
  logic [DUTY_W-1:0] lo  [NUM_GEN];
  logic              pin_en  [NUM_PINS];
  logic [SEL_W-1:0]  pin_sel [NUM_PINS];
  logic [NUM_GEN-1:0] wave;

  wgb_regs #(
    .NUM_GEN (NUM_GEN),
    .NUM_DIR (NUM_DIR),
    .NUM_SER (NUM_SER),
    .AW      (AW)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .per_o     (per),
    .hi_o      (hi),
    .lo_o      (lo),
    .pin_en_o  (pin_en),
    .pin_sel_o (pin_sel)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    wgb_gen u_gen (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .per_i  (per[g]),
      .hi_i   (hi[g]),
      .lo_i   (lo[g]),
      .wave_o (wave[g])
    );
  end

  wgb_pinmux #(
    .NUM_GEN  (NUM_GEN),
    .NUM_PINS (NUM_PINS)
  ) u_pinmux (
    .wave_i    (wave),
    .pin_en_i  (pin_en),
    .pin_sel_i (pin_sel),
    .pins_o    (pins_o)
  );
endmodule

// File: tb/wgb_bank_tb.sv
module wgb_bank_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [32:0] pins;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tick_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  string cur_req = "R4";
  bit cmp_on = 0;
  bit done = 0;

  // model: programmed values, active values, elapsed ticks in current period
  int m_per [8], m_hi [8], m_lo [8];
  int a_per [8], a_hi [8], a_lo [8], m_e [8];
  bit m_en [33];
  int m_sel [33];

  wgb_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pins_o(pins)
  );

  always #4 clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void mdl_write(int a, logic [31:0] d);
    if (a <= 1) begin
      for (int k = 0; k < 4; k++) m_per[a*4+k] = int'(d[k*8 +: 8]);
    end else if (a <= 5) begin
      for (int k = 0; k < 2; k++) begin
        m_hi[(a-2)*2+k] = int'(d[k*16 +: 8]);
        m_lo[(a-2)*2+k] = int'(d[k*16+8 +: 8]);
      end
    end else if (a <= 10) begin
      for (int k = 0; k < 8; k++) begin
        int p;
        p = (a <= 7) ? (a-6)*8+k : 16+(a-8)*8+k;
        if (p < 33) begin
          m_en[p]  = d[k*4+3];
          m_sel[p] = int'(d[k*4 +: 3]);
        end
      end
    end
  endfunction

  function automatic logic [31:0] mdl_read(int a);
    logic [31:0] r;
    r = '0;
    if (a <= 1) begin
      for (int k = 0; k < 4; k++) r[k*8 +: 8] = 8'(m_per[a*4+k]);
    end else if (a <= 5) begin
      for (int k = 0; k < 2; k++) begin
        r[k*16 +: 8]   = 8'(m_hi[(a-2)*2+k]);
        r[k*16+8 +: 8] = 8'(m_lo[(a-2)*2+k]);
      end
    end else if (a <= 10) begin
      for (int k = 0; k < 8; k++) begin
        int p;
        p = (a <= 7) ? (a-6)*8+k : 16+(a-8)*8+k;
        if (p < 33) r[k*4 +: 4] = {m_en[p], 3'(m_sel[p])};
      end
    end
    return r;
  endfunction

  function automatic int mdl_len(int g);
    return a_per[g] * (((a_hi[g] + a_lo[g]) == 0) ? 1 : (a_hi[g] + a_lo[g]));
  endfunction

  function automatic bit mdl_wave(int g);
    return (a_per[g] != 0) && (m_e[g] < a_per[g] * a_hi[g]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 8; g++) begin
        m_per[g] = 0; m_hi[g] = 0; m_lo[g] = 0;
        a_per[g] = 0; a_hi[g] = 0; a_lo[g] = 0; m_e[g] = 0;
      end
      for (int p = 0; p < 33; p++) begin m_en[p] = 0; m_sel[p] = 0; end
    end else begin
      for (int g = 0; g < 8; g++) begin
        if (a_per[g] == 0) begin
          a_per[g] = m_per[g]; a_hi[g] = m_hi[g]; a_lo[g] = m_lo[g]; m_e[g] = 0;
        end else if (tick) begin
          m_e[g]++;
          if (m_e[g] == mdl_len(g)) begin
            a_per[g] = m_per[g]; a_hi[g] = m_hi[g]; a_lo[g] = m_lo[g]; m_e[g] = 0;
          end
        end
      end
      if (we) mdl_write(int'(addr), wdata);
    end
  end

  always @(negedge clk) begin
    cyc++;
    case (tick_mode)
      0: tick = 1'b1;
      1: begin lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; tick = lfsr[0]; end
      default: tick = 1'b0;
    endcase
    if (rst_n && cmp_on) begin
      for (int p = 0; p < 33; p++) begin
        bit e;
        e = m_en[p] && mdl_wave(m_sel[p]);
        chk(pins[p] == e, cur_req, $sformatf("pin %0d vs model cyc %0d", p, cyc), int'(pins[p]), int'(e));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1;
      chk(1'b0, "WD", "watchdog expired", cyc, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, string req);
    logic [31:0] exp;
    @(negedge clk);
    addr = 4'(a);
    #1;
    exp = mdl_read(a);
    chk(rdata == exp, req, $sformatf("read word %0d", a), int'(rdata), int'(exp));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(pins == '0, "R1", "pins after reset", int'(pins[31:0]), 0);
    for (int a = 0; a < 11; a++) begin
      @(negedge clk); addr = 4'(a); #1;
      chk(rdata == 32'h0, "R1", $sformatf("reset read word %0d", a), int'(rdata), 0);
    end
    cmp_on = 1;

    // R2: layout, readback, unused bits and addresses
    wr(2, 32'h01010203);
    wr(3, 32'h040000FF);
    wr(4, 32'h00050000);
    wr(5, 32'h03029B64);
    wr(6, 32'hFEDCBA98);
    wr(7, 32'hFEDCBA98);
    wr(8, 32'hFED2BA98);
    wr(9, 32'hFEDCBA98);
    wr(10, 32'hFFFFFFF8);
    wr(13, 32'hDEADBEEF);
    wr(0, 32'h01010201);
    wr(1, 32'h02010001);
    rd(10, "R2");
    chk(rdata == 32'h8, "R2", "unused bits of word 10", int'(rdata), 8);
    rd(13, "R2");
    chk(rdata == 32'h0, "R2", "unmapped word 13", int'(rdata), 0);
    rd(3, "R2");
    chk(rdata == 32'h040000FF, "R2", "duty word 3", int'(rdata), 32'h040000FF);
    for (int a = 0; a < 11; a++) rd(a, "R2");

    // R4: every-clock then irregular time base
    cur_req = "R4";
    idle(300);
    // R3 R6 R9 explicit checks while running
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      chk(pins[20] == 1'b0, "R3", "disabled pin 20 on full-on generator", int'(pins[20]), 0);
      chk(pins[2] == 1'b1, "R6", "full-on pin 2", int'(pins[2]), 1);
      chk(pins[3] == 1'b0, "R6", "zero-high pin 3", int'(pins[3]), 0);
      chk(pins[1] == pins[9] && pins[9] == pins[17] && pins[17] == pins[25], "R9",
          "pins 1/9/17/25 share generator 1", int'({pins[25], pins[17], pins[9], pins[1]}), 0);
    end
    tick_mode = 1;
    idle(400);
    tick_mode = 2;
    idle(20);
    tick_mode = 0;

    // R7: rewrite duty of generator 6 mid-period
    cur_req = "R7";
    while (!(a_hi[6] == 100 && m_e[6] == 20)) @(negedge clk);
    wr(5, 32'h0302F50A);
    idle(40);
    chk(pins[6] == 1'b1, "R7", "pin 6 keeps old high span", int'(pins[6]), 1);
    while (a_hi[6] != 10) @(negedge clk);
    idle(15);
    chk(pins[6] == 1'b0, "R7", "pin 6 uses new high span", int'(pins[6]), 0);

    // R8: write on the exact boundary of generator 1
    cur_req = "R8";
    while (!(a_per[1] != 0 && m_e[1] == mdl_len(1) - 1)) @(negedge clk);
    we = 1'b1; addr = 4'd2; wdata = 32'h01030203;
    @(negedge clk);
    we = 1'b0;
    chk(pins[1] == 1'b1, "R8", "pin 1 first step after boundary", int'(pins[1]), 1);
    idle(2);
    chk(pins[1] == 1'b0, "R8", "pin 1 old split kept one period", int'(pins[1]), 0);
    idle(2);
    idle(4);
    chk(pins[1] == 1'b1, "R8", "pin 1 new split after next boundary", int'(pins[1]), 1);

    // R5: period 0 idles generator 0, restart on nonzero period
    cur_req = "R5";
    wr(0, 32'h01010200);
    idle(20);
    chk(pins[0] == 1'b0, "R5", "idle pin 0", int'(pins[0]), 0);
    chk(pins[8] == 1'b0, "R5", "idle pin 8", int'(pins[8]), 0);
    tick_mode = 2;
    wr(0, 32'h01010201);
    chk(pins[0] == 1'b0, "R5", "pin 0 one clock after write", int'(pins[0]), 0);
    @(negedge clk);
    chk(pins[0] == 1'b1, "R5", "pin 0 starts high", int'(pins[0]), 1);
    idle(5);
    chk(pins[0] == 1'b1, "R5", "pin 0 holds without ticks", int'(pins[0]), 1);
    tick_mode = 0;
    idle(30);

    // R3: disabling a pin through the map
    cur_req = "R3";
    wr(6, 32'hFEDCBA90);
    idle(3);
    chk(pins[0] == 1'b0, "R3", "pin 0 disabled by map", int'(pins[0]), 0);
    for (int a = 0; a < 11; a++) rd(a, "R2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule